// File: doc/BRIEF.md
# Indirect Register Port with Auto-Increment

This block is the host-side register access front end of a bus interface controller. The host sees two byte-wide ports, chosen by `h_port`. A write to the pointer port (`h_port`=0) loads an internal register pointer. A read of the same port returns an auxiliary status byte, not the pointer. The data port (`h_port`=1) reads or writes the register that the pointer selects. After every data-port access the pointer moves on by one. A multi-byte field, such as the 24-bit transfer count, can therefore be streamed after a single pointer write.

The block holds a 28-byte register file at locations 0 to 27. A 24-bit transfer count sits at locations 18 to 20, most significant byte first. The command byte sits at location 24. The core drives two gating flags, busy and command-in-progress. These flags restrict which locations the host may touch. A command write that the gating blocks is discarded and is reported through the status byte. An accepted command produces a one-cycle strobe to the core. The core can count the transfer count down with a decrement input.

Top module: `regport_front`

## Requirements
- R1: A write to the pointer port loads the pointer with the written value. A value above 27 loads 27. A read of the pointer port never returns the pointer.
- R2: A data-port access reads or writes the location at the pointer. After it the pointer becomes pointer+1. Read data is combinational during the read cycle, and write data takes effect at that clock edge.
- R3: A data-port access with the pointer at 27 leaves the pointer at 27.
- R4: Locations 18, 19 and 20 read and write bits 23:16, 15:8 and 7:0 of the transfer count. A pointer write of 18 followed by three data writes loads those three bytes in that order.
- R5: A pointer-port read returns {irq, last-command-ignored, busy, cip, 0, 0, parity-error, data-ready}, from bit 7 down to bit 0. Bits 3:2 are always 0.
- R6: While busy is 1, only locations 24 and 25 are accessible. A data write to any other location changes nothing. A data read of any other location returns 0x00.
- R7: While cip is 1, location 24 is blocked as well. A data write to 24 while cip is 1 is discarded and sets last-command-ignored. A pointer-port read clears last-command-ignored after returning it.
- R8: An accepted data write to location 24 raises `cmd_strobe` for exactly the next cycle. `cmd_sbt` carries bit 7 of the written byte and `cmd_op` carries bits 6:0.
- R9: When `cnt_dec` is 1, the count decreases by one. At zero the count stays at zero. A host write to a count byte in the same cycle wins over the decrement. The count reaches 0xFFFFFF, and `cnt_zero` is 1 exactly when the count is 0.
- R10: A synchronous reset clears the pointer, every location, the count and last-command-ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| h_port | input | 1 | 0 selects the pointer/status port, 1 selects the data port |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| core_busy | input | 1 | Core busy flag |
| core_cip | input | 1 | Core command-in-progress flag |
| core_irq | input | 1 | Interrupt pending, shown in the status byte |
| core_perr | input | 1 | Parity error, shown in the status byte |
| core_dbr | input | 1 | Data buffer ready, shown in the status byte |
| cnt_dec | input | 1 | Decrement the transfer count |
| cmd_strobe | output | 1 | One-cycle pulse after an accepted command write |
| cmd_sbt | output | 1 | Single-byte-transfer qualifier of the held command |
| cmd_op | output | 7 | Command code of the held command |
| cnt_zero | output | 1 | Transfer count is zero |

## Verification
The bench builds the block with its default parameters: 28 locations, the count at 18 to 20, the command at 24 and the data byte at 25. With this map, pointer saturation at 27 and the busy and cip gates are reachable from ordinary random pointer values. Short directed loads also reach a full count of 0xFFFFFF and a count decremented to zero. Random traffic mixes both flags with pointer and data operations, so blocked writes, discarded commands and status-read clearing happen many times against the bench's own model.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam int unsigned BYTE_W = 8;

  // Pointer advance: saturating increment.
  function automatic int sat_inc(input int p, input int last);
    return (p >= last) ? last : p + 1;
  endfunction

  // Pointer load: clip to last location.
  function automatic int clip_ptr(input int v, input int last);
    return (v > last) ? last : v;
  endfunction

  // Gating: busy leaves command and data; cip removes command too.
  function automatic logic may_access(input int p, input int cmd_a, input int data_a,
                                      input logic busy, input logic cip);
    if (!busy && !cip) return 1'b1;
    if (p == data_a)   return 1'b1;
    if (p == cmd_a)    return !cip;
    return 1'b0;
  endfunction

  // Auxiliary status byte.
  function automatic logic [7:0] asr_pack(input logic irq, input logic lci, input logic busy,
                                          input logic cip, input logic perr, input logic dbr);
    return {irq, lci, busy, cip, 2'b00, perr, dbr};
  endfunction

endpackage

// File: rtl/regport_ptr.sv
module regport_ptr
  import regport_pkg::*;
#(
  parameter int NUM_REGS = 28,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int LAST = NUM_REGS - 1;

  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = PTR_W'(clip_ptr(int'(load_val), LAST));
    else if (step) ptr_d = PTR_W'(sat_inc(int'(ptr_q), LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(ptr_q) <= LAST);  // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> int'(ptr_q) == sat_inc(int'($past(ptr_q)), LAST));  // R2

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> int'(ptr_q) == clip_ptr(int'($past(load_val)), LAST));  // R1

endmodule

// File: rtl/regport_file.sv
module regport_file
  import regport_pkg::*;
#(
  parameter int NUM_REGS  = 28,
  parameter int PTR_W     = $clog2(NUM_REGS),
  parameter int CNT_BASE  = 18,
  parameter int CNT_BYTES = 3,
  parameter int CMD_ADDR  = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [PTR_W-1:0]            ptr,
  input  logic                        wr_en,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        dec,
  output logic [BYTE_W-1:0]           rd_byte,
  output logic [BYTE_W-1:0]           cmd_q,
  output logic                        cmd_stb,
  output logic [CNT_BYTES*BYTE_W-1:0] cnt_q
);
  localparam int CNT_W = CNT_BYTES * BYTE_W;

  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic [CNT_W-1:0]  cnt_d;
  logic              cnt_hit;

  function automatic logic is_cnt(input int p);
    return (p >= CNT_BASE) && (p < CNT_BASE + CNT_BYTES);
  endfunction

  // Count: host byte write wins over decrement; floor at zero.
  always_comb begin
    cnt_d   = cnt_q;
    cnt_hit = 1'b0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (wr_en && int'(ptr) == CNT_BASE + b) begin
        cnt_d[(CNT_BYTES-1-b)*BYTE_W +: BYTE_W] = wdata;
        cnt_hit = 1'b1;
      end
    end
    if (!cnt_hit && dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cmd_stb <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else begin
      cnt_q   <= cnt_d;
      cmd_stb <= wr_en && int'(ptr) == CMD_ADDR;
      for (int i = 0; i < NUM_REGS; i++)
        if (wr_en && int'(ptr) == i && !is_cnt(i)) regs_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_byte = regs_q[ptr];
    for (int b = 0; b < CNT_BYTES; b++)
      if (int'(ptr) == CNT_BASE + b) rd_byte = cnt_q[(CNT_BYTES-1-b)*BYTE_W +: BYTE_W];
  end

  assign cmd_q = regs_q[CMD_ADDR];

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (rst)
    (dec && !cnt_hit && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);  // R9

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (!cnt_hit && cnt_q == '0) |=> cnt_q == '0);  // R9

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);  // R8

endmodule

// File: rtl/regport_asr.sv
module regport_asr
  import regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_lci,
  input  logic              clr_lci,
  input  logic              busy,
  input  logic              cip,
  input  logic              irq,
  input  logic              perr,
  input  logic              dbr,
  output logic [BYTE_W-1:0] asr
);
  logic lci_q;

  always_ff @(posedge clk) begin
    if (rst)          lci_q <= 1'b0;
    else if (set_lci) lci_q <= 1'b1;
    else if (clr_lci) lci_q <= 1'b0;
  end

  assign asr = asr_pack(irq, lci_q, busy, cip, perr, dbr);

  AST_LCI_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_lci && !set_lci) |=> !asr[6]);  // R7

endmodule

// File: rtl/regport_front.sv
module regport_front
  import regport_pkg::*;
#(
  parameter int NUM_REGS  = 28,
  parameter int CNT_BASE  = 18,
  parameter int CNT_BYTES = 3,
  parameter int CMD_ADDR  = 24,
  parameter int DATA_ADDR = 25
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        h_port,
  input  logic        h_wr,
  input  logic        h_rd,
  input  logic [7:0]  h_wdata,
  output logic [7:0]  h_rdata,
  input  logic        core_busy,
  input  logic        core_cip,
  input  logic        core_irq,
  input  logic        core_perr,
  input  logic        core_dbr,
  input  logic        cnt_dec,
  output logic        cmd_strobe,
  output logic        cmd_sbt,
  output logic [6:0]  cmd_op,
  output logic        cnt_zero
);
  localparam int PTR_W = $clog2(NUM_REGS);
  localparam int CNT_W = CNT_BYTES * BYTE_W;

  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] rd_byte, cmd_q, asr;
  logic [CNT_W-1:0]  cnt_q;

  // Named host events.
  logic ev_ptr_wr, ev_asr_rd, ev_data_acc, ev_data_wr, ev_ok, ev_cmd_drop;

  assign ev_ptr_wr   = h_wr && !h_port;
  assign ev_asr_rd   = h_rd && !h_port;
  assign ev_data_acc = h_port && (h_wr || h_rd);
  assign ev_data_wr  = h_port && h_wr;
  assign ev_ok       = may_access(int'(ptr), CMD_ADDR, DATA_ADDR, core_busy, core_cip);
  assign ev_cmd_drop = ev_data_wr && core_cip && int'(ptr) == CMD_ADDR;

  regport_ptr #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .load(ev_ptr_wr), .load_val(h_wdata),
    .step(ev_data_acc), .ptr_q(ptr)
  );

  regport_file #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .CNT_BASE(CNT_BASE),
                 .CNT_BYTES(CNT_BYTES), .CMD_ADDR(CMD_ADDR)) u_file (
    .clk(clk), .rst(rst), .ptr(ptr), .wr_en(ev_data_wr && ev_ok), .wdata(h_wdata),
    .dec(cnt_dec), .rd_byte(rd_byte), .cmd_q(cmd_q), .cmd_stb(cmd_strobe), .cnt_q(cnt_q)
  );

  regport_asr u_asr (
    .clk(clk), .rst(rst), .set_lci(ev_cmd_drop), .clr_lci(ev_asr_rd),
    .busy(core_busy), .cip(core_cip), .irq(core_irq), .perr(core_perr),
    .dbr(core_dbr), .asr(asr)
  );

  assign h_rdata  = !h_port ? asr : (ev_ok ? rd_byte : '0);
  assign cmd_sbt  = cmd_q[7];
  assign cmd_op   = cmd_q[6:0];
  assign cnt_zero = (cnt_q == '0);

  AST_LCI_ON_DROP: assert property (@(posedge clk) disable iff (rst)
    ev_cmd_drop |=> asr[6]);  // R7

  AST_STB_NOT_CIP: assert property (@(posedge clk) disable iff (rst)
    cmd_strobe |-> $past(!core_cip && core_busy == core_busy));  // R7

  AST_ASR_RSVD: assert property (@(posedge clk) disable iff (rst)
    ev_asr_rd |-> h_rdata[3:2] == 2'b00);  // R5

  AST_BUSY_BLOCK_CNT: assert property (@(posedge clk) disable iff (rst)
    (core_busy && !cnt_dec) |=> $stable(cnt_q));  // R6

endmodule

// File: tb/regport_front_bench.sv
`timescale 1ns/1ps
module regport_front_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_port = 0, h_wr = 0, h_rd = 0;
  logic [7:0] h_wdata = 0;
  logic [7:0] h_rdata;
  logic core_busy = 0, core_cip = 0, core_irq = 0, core_perr = 0, core_dbr = 0;
  logic cnt_dec = 0;
  logic cmd_strobe, cmd_sbt, cnt_zero;
  logic [6:0] cmd_op;

  int checks = 0, errors = 0;
  bit done = 0;

  int         mptr;
  logic [7:0] mregs [28];
  logic [23:0] mcnt;
  logic       mlci;

  always #2.5 clk = ~clk;

  regport_front u_regport_front (
    .clk(clk), .rst(rst), .h_port(h_port), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .core_busy(core_busy), .core_cip(core_cip),
    .core_irq(core_irq), .core_perr(core_perr), .core_dbr(core_dbr), .cnt_dec(cnt_dec),
    .cmd_strobe(cmd_strobe), .cmd_sbt(cmd_sbt), .cmd_op(cmd_op), .cnt_zero(cnt_zero)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mok(input int p);
    if (!core_busy && !core_cip) return 1'b1;
    if (p == 25) return 1'b1;
    if (p == 24) return !core_cip;
    return 1'b0;
  endfunction

  function automatic logic [7:0] mread(input logic port);
    if (!port) return {core_irq, mlci, core_busy, core_cip, 2'b00, core_perr, core_dbr};
    if (!mok(mptr)) return 8'h00;
    if (mptr >= 18 && mptr <= 20) return mcnt[(20-mptr)*8 +: 8];
    return mregs[mptr];
  endfunction

  task automatic op(input logic port, input logic wr, input logic rd,
                    input logic [7:0] w, input logic dec, input string req);
    logic stb = 0;
    logic cw = 0;
    @(negedge clk);
    h_port = port; h_wr = wr; h_rd = rd; h_wdata = w; cnt_dec = dec;
    #1;
    if (rd) check(h_rdata, mread(port), req);
    @(posedge clk);
    if (wr && !port) mptr = (w > 27) ? 27 : int'(w);
    if (port && (wr || rd)) begin
      if (wr) begin
        if (mok(mptr)) begin
          if (mptr >= 18 && mptr <= 20) begin
            mcnt[(20-mptr)*8 +: 8] = w; cw = 1;
          end else begin
            mregs[mptr] = w;
            if (mptr == 24) stb = 1;
          end
        end else if (mptr == 24 && core_cip) mlci = 1;
      end
      mptr = (mptr >= 27) ? 27 : mptr + 1;
    end
    if (rd && !port) mlci = 0;
    if (dec && !cw && mcnt != 0) mcnt = mcnt - 1;
    #1;
    check(cmd_strobe, stb, {req, " R8 strobe"});
    if (stb) check({cmd_sbt, cmd_op}, w, "R8 code");
    h_wr = 0; h_rd = 0; cnt_dec = 0;
  endtask

  task automatic pwr(input logic [7:0] v, input string r); op(0, 1, 0, v, 0, r); endtask
  task automatic dwr(input logic [7:0] v, input string r); op(1, 1, 0, v, 0, r); endtask
  task automatic drd(input string r);                      op(1, 0, 1, 0, 0, r); endtask
  task automatic ard(input string r);                      op(0, 0, 1, 0, 0, r); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234abcd));
    mptr = 0; mcnt = 0; mlci = 0;
    for (int i = 0; i < 28; i++) mregs[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;

    // R10: reset state
    ard("R10 status after reset");
    drd("R10 location 0 after reset");
    check(cnt_zero, 1'b1, "R10 count zero");

    // R2: write two, read back two
    pwr(8'd5, "R1"); dwr(8'hA1, "R2"); dwr(8'hB2, "R2");
    pwr(8'd5, "R1"); drd("R2 read loc5"); drd("R2 read loc6");

    // R4: count streamed high to low
    pwr(8'd18, "R4"); dwr(8'h12, "R4"); dwr(8'h34, "R4"); dwr(8'h56, "R4");
    pwr(8'd18, "R4"); drd("R4 hi"); drd("R4 mid"); drd("R4 lo");

    // R3 / R1: saturation
    pwr(8'd27, "R3"); dwr(8'h11, "R3"); dwr(8'h22, "R3"); drd("R3 loc27 stays");
    pwr(8'd200, "R1"); drd("R1 clipped pointer");

    // R5: status layout
    core_irq = 1; core_perr = 1; core_dbr = 1;
    ard("R5 status layout");
    core_irq = 0; core_perr = 0; core_dbr = 0;

    // R6: busy gating
    pwr(8'd3, "R6"); dwr(8'h3C, "R6");
    core_busy = 1;
    pwr(8'd3, "R6"); dwr(8'h77, "R6 blocked write"); pwr(8'd3, "R6"); drd("R6 blocked read");
    pwr(8'd25, "R6"); dwr(8'h5A, "R6"); pwr(8'd25, "R6"); drd("R6 data open");
    core_busy = 0;
    pwr(8'd3, "R6"); drd("R6 loc3 unchanged");

    // R7: command dropped under cip
    core_busy = 1; core_cip = 1;
    pwr(8'd24, "R7"); dwr(8'h05, "R7 dropped command");
    ard("R7 lci set"); ard("R7 lci cleared");
    core_cip = 0;
    pwr(8'd24, "R7"); drd("R7 command unchanged");

    // R8: accepted command while busy
    pwr(8'd24, "R8"); dwr(8'h95, "R8 accepted");
    core_busy = 0;

    // R9: max count, decrement, floor, write wins
    pwr(8'd18, "R9"); dwr(8'hFF, "R9"); dwr(8'hFF, "R9"); dwr(8'hFF, "R9");
    pwr(8'd18, "R9"); drd("R9 max hi"); drd("R9 max mid"); drd("R9 max lo");
    pwr(8'd18, "R9"); dwr(8'h00, "R9"); dwr(8'h00, "R9"); dwr(8'h01, "R9");
    op(0, 0, 0, 0, 1, "R9 dec"); op(0, 0, 0, 0, 1, "R9 dec at zero");
    check(cnt_zero, 1'b1, "R9 cnt_zero");
    pwr(8'd20, "R9"); op(1, 1, 0, 8'h09, 1, "R9 write wins");
    pwr(8'd20, "R9"); drd("R9 write wins readback");

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int k;
      core_busy = ($urandom_range(0, 3) == 0);
      core_cip  = core_busy && ($urandom_range(0, 2) == 0);
      core_irq  = $urandom_range(0, 1);
      core_perr = $urandom_range(0, 1);
      core_dbr  = $urandom_range(0, 1);
      k = $urandom_range(0, 9);
      case (k)
        0, 1:    pwr(8'($urandom_range(0, 31)), "R1 random");
        2, 3, 4: op(1, 1, 0, 8'($urandom), $urandom_range(0, 1), "R6 random write");
        5, 6, 7: op(1, 0, 1, 0, $urandom_range(0, 1), "R2 random read");
        8:       ard("R5 random status");
        default: op(0, 0, 0, 0, 1, "R9 random dec");
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule